// File: doc/BRIEF.md
# 16-bit Arithmetic Unit with Excess Word

This block is the arithmetic stage of a small 16-bit processor. It receives an opcode, two operands (the destination operand `b` and the source operand `a`) and the current excess word, then returns the new destination value. It also returns a new excess word with its write enable, a condition outcome for the test opcodes and the architectural cycle cost of the operation. Every arithmetic and shift opcode defines a full 16-bit side result for the excess word. That side result carries the carry, the borrow, the upper product half, the fractional quotient or the bits shifted out. Two opcodes also take the excess word in as a carry-in.

Operation is started with a one-cycle `start_i` pulse. All opcodes except the three dividing ones finish in one clock. Divide and remainder use an iterative restoring divider, and a start that arrives while that divider is working is dropped. Results are registered and stay on the outputs until the next completion. Operand fetch, writeback and skipping of the following instruction belong to the surrounding core.

Top module: `alu_ex_core`

## Requirements
- R1: A `start_i` pulse is accepted only when no divide is in progress. For any opcode outside the divide group, `done_o` is high for exactly one cycle, on the clock following acceptance. A `start_i` that arrives during a divide is ignored, produces no completion, and does not change the divide's outputs.
- R2: Opcode 0x02 gives b+a with EX = 0x0001 on carry out of bit 15, else 0. Opcode 0x03 gives b-a with EX = 0xffff when a > b, else 0.
- R3: Opcode 0x1a gives b+a+EX with new EX = 0x0001 if the true sum exceeds 0xffff, else 0. Opcode 0x1b gives b-a+EX with new EX = 0xffff if the true value is negative, else 0.
- R4: Opcode 0x04 returns the low half of the unsigned 32-bit product and writes the high half to EX. Opcode 0x05 does the same with a two's-complement signed product.
- R5: Opcode 0x06 (unsigned) returns b/a and writes EX = low 16 bits of (b·65536)/a.
- R6: Opcode 0x07 (signed) returns b/a truncated toward zero and writes EX = low 16 bits of (b·65536)/a, also truncated toward zero.
- R7: With a = 0, opcodes 0x06 and 0x07 return 0 and write EX = 0. Opcode 0x08 returns 0.
- R8: Opcode 0x08 returns the unsigned remainder b mod a and leaves EX unwritten (`ex_we_o` low).
- R9: Opcode 0x0c returns b>>a (logical) with EX = low half of (b·65536)>>a. Opcode 0x0d shifts arithmetically and takes EX from the arithmetic shift of b·65536. Opcode 0x0e returns b<<a with EX = the bits shifted above bit 15. Shift counts of 32 or more are legal.
- R10: Opcode 0x01 returns a. Opcodes 0x09, 0x0a and 0x0b return b&a, b|a and b^a. None of these four writes EX. Any unlisted opcode returns b, does not write EX, reports condition 1 and a cost of 1.
- R11: The test opcodes report `cond_o`: 0x10 (b&a)≠0, 0x11 (b&a)=0, 0x12 b=a, 0x13 b≠a, 0x14 b>a unsigned, 0x15 b>a signed, 0x16 b<a unsigned, 0x17 b<a signed. They do not write EX. Every non-test opcode reports `cond_o` = 1.
- R12: `cycles_o` reports the cost: 1 for 0x01, 0x09–0x0b. It reports 2 for 0x02–0x05 and 0x0c–0x0e, and 3 for 0x06–0x08, 0x1a and 0x1b. A test opcode reports 2 when its condition holds and 3 when it fails.
- R13: A divide-group opcode (0x06–0x08) raises `done_o` for one cycle no later than 2·16+2 clocks after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin operation on the present inputs |
| op_i | input | 5 | Opcode |
| b_i | input | 16 | Destination operand |
| a_i | input | 16 | Source operand |
| ex_i | input | 16 | Current excess word |
| result_o | output | 16 | New destination value |
| ex_o | output | 16 | New excess word |
| ex_we_o | output | 1 | Excess word write enable |
| cond_o | output | 1 | Test outcome, 1 = execute next instruction |
| cycles_o | output | 2 | Architectural cycle cost |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The arithmetic opcodes are run with operand pairs placed just below and just above the carry, borrow and sign boundaries. This separates a correct EX side result from one that is off by one or has the wrong sign. Signed divides use all four sign combinations and odd quotients, which exposes rounding toward minus infinity and wrong negation of the fractional word. Shifts use counts of 0, mid range, 16 and beyond 32 to catch truncated shift amounts. Every test opcode is checked with a passing and a failing operand pair, including pairs where the signed and unsigned orderings disagree, so that the cost and the outcome are both checked.

// File: rtl/alu_ex_pkg.sv
package alu_ex_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned OPW = 5;
  localparam int unsigned CYW = 2;

  localparam logic [OPW-1:0] OP_MOVE  = 5'h01;
  localparam logic [OPW-1:0] OP_ADD   = 5'h02;
  localparam logic [OPW-1:0] OP_SUB   = 5'h03;
  localparam logic [OPW-1:0] OP_MULU  = 5'h04;
  localparam logic [OPW-1:0] OP_MULS  = 5'h05;
  localparam logic [OPW-1:0] OP_DIVU  = 5'h06;
  localparam logic [OPW-1:0] OP_DIVS  = 5'h07;
  localparam logic [OPW-1:0] OP_REMU  = 5'h08;
  localparam logic [OPW-1:0] OP_AND   = 5'h09;
  localparam logic [OPW-1:0] OP_OR    = 5'h0a;
  localparam logic [OPW-1:0] OP_XOR   = 5'h0b;
  localparam logic [OPW-1:0] OP_SRL   = 5'h0c;
  localparam logic [OPW-1:0] OP_SRA   = 5'h0d;
  localparam logic [OPW-1:0] OP_SLL   = 5'h0e;
  localparam logic [OPW-1:0] OP_T_ANY = 5'h10;
  localparam logic [OPW-1:0] OP_T_NON = 5'h11;
  localparam logic [OPW-1:0] OP_T_EQ  = 5'h12;
  localparam logic [OPW-1:0] OP_T_NE  = 5'h13;
  localparam logic [OPW-1:0] OP_T_GTU = 5'h14;
  localparam logic [OPW-1:0] OP_T_GTS = 5'h15;
  localparam logic [OPW-1:0] OP_T_LTU = 5'h16;
  localparam logic [OPW-1:0] OP_T_LTS = 5'h17;
  localparam logic [OPW-1:0] OP_ADDC  = 5'h1a;
  localparam logic [OPW-1:0] OP_SUBC  = 5'h1b;

  function automatic logic is_div(input logic [OPW-1:0] op);
    return (op == OP_DIVU) || (op == OP_DIVS) || (op == OP_REMU);
  endfunction

  function automatic logic is_test(input logic [OPW-1:0] op);
    return op[4:3] == 2'b10;
  endfunction

  function automatic logic is_plain(input logic [OPW-1:0] op);
    return (op == OP_MOVE) || (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction
endpackage

// File: rtl/alu_ex_fast.sv
module alu_ex_fast
  import alu_ex_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   ex_i,
  output logic [W-1:0]   res_o,
  output logic [W-1:0]   ex_o,
  output logic           ex_we_o,
  output logic           cond_o,
  output logic [CYW-1:0] cyc_o
);
  localparam int unsigned W2 = 2 * W;
  localparam logic [W-1:0] EX_ONE = W'(1);
  localparam logic [W-1:0] EX_ALL = '1;

  logic [W:0]    add_s;
  logic [W+1:0]  adc_s;
  logic          sbc_neg;
  logic [W2-1:0] mul_u, mul_s, srl_v, sra_v, sll_v;
  logic          t_eq, t_gtu, t_gts, t_ltu, t_lts, t_any;

  assign add_s   = {1'b0, b_i} + {1'b0, a_i};
  assign adc_s   = {2'b00, b_i} + {2'b00, a_i} + {2'b00, ex_i};
  assign sbc_neg = ({1'b0, b_i} + {1'b0, ex_i}) < {1'b0, a_i};
  assign mul_u   = {{W{1'b0}}, b_i} * {{W{1'b0}}, a_i};
  assign mul_s   = {{W{b_i[W-1]}}, b_i} * {{W{a_i[W-1]}}, a_i};
  assign srl_v   = {b_i, {W{1'b0}}} >> a_i;
  assign sra_v   = W2'($signed({b_i, {W{1'b0}}}) >>> a_i);
  assign sll_v   = {{W{1'b0}}, b_i} << a_i;

  assign t_eq  = b_i == a_i;
  assign t_gtu = b_i > a_i;
  assign t_ltu = b_i < a_i;
  assign t_gts = $signed(b_i) > $signed(a_i);
  assign t_lts = $signed(b_i) < $signed(a_i);
  assign t_any = |(b_i & a_i);

  always_comb begin
    res_o   = b_i;
    ex_o    = '0;
    ex_we_o = 1'b0;
    cond_o  = 1'b1;
    cyc_o   = CYW'(1);
    unique case (op_i)
      OP_MOVE: res_o = a_i;
      OP_AND:  res_o = b_i & a_i;
      OP_OR:   res_o = b_i | a_i;
      OP_XOR:  res_o = b_i ^ a_i;
      OP_ADD: begin
        res_o = add_s[W-1:0]; ex_o = add_s[W] ? EX_ONE : '0;
        ex_we_o = 1'b1; cyc_o = CYW'(2);
      end
      OP_SUB: begin
        res_o = b_i - a_i; ex_o = t_ltu ? EX_ALL : '0;
        ex_we_o = 1'b1; cyc_o = CYW'(2);
      end
      OP_ADDC: begin
        res_o = adc_s[W-1:0]; ex_o = (|adc_s[W+1:W]) ? EX_ONE : '0;
        ex_we_o = 1'b1; cyc_o = CYW'(3);
      end
      OP_SUBC: begin
        res_o = b_i - a_i + ex_i; ex_o = sbc_neg ? EX_ALL : '0;
        ex_we_o = 1'b1; cyc_o = CYW'(3);
      end
      OP_MULU: begin
        res_o = mul_u[W-1:0]; ex_o = mul_u[W2-1:W];
        ex_we_o = 1'b1; cyc_o = CYW'(2);
      end
      OP_MULS: begin
        res_o = mul_s[W-1:0]; ex_o = mul_s[W2-1:W];
        ex_we_o = 1'b1; cyc_o = CYW'(2);
      end
      OP_SRL: begin
        res_o = srl_v[W2-1:W]; ex_o = srl_v[W-1:0];
        ex_we_o = 1'b1; cyc_o = CYW'(2);
      end
      OP_SRA: begin
        res_o = sra_v[W2-1:W]; ex_o = sra_v[W-1:0];
        ex_we_o = 1'b1; cyc_o = CYW'(2);
      end
      OP_SLL: begin
        res_o = sll_v[W-1:0]; ex_o = sll_v[W2-1:W];
        ex_we_o = 1'b1; cyc_o = CYW'(2);
      end
      OP_T_ANY, OP_T_NON, OP_T_EQ, OP_T_NE,
      OP_T_GTU, OP_T_GTS, OP_T_LTU, OP_T_LTS: begin
        unique case (op_i[2:0])
          3'd0: cond_o = t_any;
          3'd1: cond_o = !t_any;
          3'd2: cond_o = t_eq;
          3'd3: cond_o = !t_eq;
          3'd4: cond_o = t_gtu;
          3'd5: cond_o = t_gts;
          3'd6: cond_o = t_ltu;
          default: cond_o = t_lts;
        endcase
        cyc_o = cond_o ? CYW'(2) : CYW'(3);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_ex_div.sv
module alu_ex_div
  import alu_ex_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic         rem_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] a_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] res_o,
  output logic [W-1:0] ex_o
);
  localparam int unsigned W2    = 2 * W;
  localparam int unsigned CNT_W = $clog2(W2 + 1);

  logic [W2-1:0]    dvd_q, quo_q;
  logic [W-1:0]     dsr_q, rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, neg_q, zero_q, rem_mode_q;

  logic [W-1:0] mag_b, mag_a;
  logic [W:0]   rem_sh;
  logic         ge;
  logic [W-1:0] rem_n;

  assign mag_b  = (signed_i && b_i[W-1]) ? (~b_i + 1'b1) : b_i;
  assign mag_a  = (signed_i && a_i[W-1]) ? (~a_i + 1'b1) : a_i;
  assign rem_sh = {rem_q, dvd_q[W2-1]};
  assign ge     = rem_sh >= {1'b0, dsr_q};
  assign rem_n  = ge ? (rem_sh[W-1:0] - dsr_q) : rem_sh[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q <= '0; quo_q <= '0; dsr_q <= '0; rem_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; neg_q <= 1'b0; zero_q <= 1'b0;
      rem_mode_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        dvd_q      <= rem_i ? {{W{1'b0}}, mag_b} : {mag_b, {W{1'b0}}};
        dsr_q      <= mag_a;
        quo_q      <= '0;
        rem_q      <= '0;
        cnt_q      <= CNT_W'(W2);
        neg_q      <= signed_i && (b_i[W-1] ^ a_i[W-1]);
        zero_q     <= a_i == '0;
        rem_mode_q <= rem_i;
        busy_q     <= 1'b1;
      end else if (busy_q) begin
        dvd_q <= dvd_q << 1;
        rem_q <= rem_n;
        quo_q <= {quo_q[W2-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (zero_q) begin
      res_o = '0;
      ex_o  = '0;
    end else if (rem_mode_q) begin
      res_o = rem_q;
      ex_o  = '0;
    end else if (neg_q) begin
      res_o = ~quo_q[W2-1:W] + 1'b1;
      ex_o  = ~quo_q[W-1:0] + 1'b1;
    end else begin
      res_o = quo_q[W2-1:W];
      ex_o  = quo_q[W-1:0];
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_DIV_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q) else $error("divide done longer than one cycle"); // R13
  AST_DIV_BUSY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && done_q)) else $error("divide busy and done together"); // R1
  AST_DIV_DROPS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && cnt_q != CNT_W'(1)) |=> busy_q) else $error("restart during divide"); // R1
endmodule

// File: rtl/alu_ex_core.sv
module alu_ex_core
  import alu_ex_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   ex_i,
  output logic [W-1:0]   result_o,
  output logic [W-1:0]   ex_o,
  output logic           ex_we_o,
  output logic           cond_o,
  output logic [CYW-1:0] cycles_o,
  output logic           done_o
);
  logic [W-1:0]   f_res, f_ex, d_res, d_ex;
  logic           f_we, f_cond, d_busy, d_done, accept, go_div;
  logic [CYW-1:0] f_cyc;
  logic [OPW-1:0] op_q;
  logic [W-1:0]   a_q;

  assign accept = start_i && !d_busy && !d_done;
  assign go_div = accept && is_div(op_i);

  alu_ex_fast #(.W(W)) u_fast (
    .op_i(op_i), .b_i(b_i), .a_i(a_i), .ex_i(ex_i),
    .res_o(f_res), .ex_o(f_ex), .ex_we_o(f_we), .cond_o(f_cond), .cyc_o(f_cyc)
  );

  alu_ex_div #(.W(W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(go_div),
    .signed_i(op_i == OP_DIVS), .rem_i(op_i == OP_REMU),
    .b_i(b_i), .a_i(a_i),
    .busy_o(d_busy), .done_o(d_done), .res_o(d_res), .ex_o(d_ex)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0; ex_o <= '0; ex_we_o <= 1'b0; cond_o <= 1'b1;
      cycles_o <= '0; done_o <= 1'b0; op_q <= '0; a_q <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        op_q <= op_i;
        a_q  <= a_i;
      end
      if (accept && !is_div(op_i)) begin
        result_o <= f_res;
        ex_o     <= f_ex;
        ex_we_o  <= f_we;
        cond_o   <= f_cond;
        cycles_o <= f_cyc;
        done_o   <= 1'b1;
      end else if (d_done) begin
        result_o <= d_res;
        ex_o     <= d_ex;
        ex_we_o  <= op_q != OP_REMU;
        cond_o   <= 1'b1;
        cycles_o <= CYW'(3);
        done_o   <= 1'b1;
      end
    end
  end

  AST_PLAIN_KEEPS_EX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_plain(op_q)) |-> !ex_we_o) else $error("plain op wrote EX"); // R10
  AST_TEST_COST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_test(op_q)) |-> (cycles_o == (cond_o ? CYW'(2) : CYW'(3))))
    else $error("test cost mismatch"); // R12
  AST_DIV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_div(op_q) && a_q == '0) |-> (result_o == '0 && ex_o == '0))
    else $error("divide by zero not cleared"); // R7
  AST_CARRY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q == OP_ADD || op_q == OP_ADDC)) |-> (ex_o == W'(0) || ex_o == W'(1)))
    else $error("carry EX out of range"); // R3
  AST_BORROW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q == OP_SUB || op_q == OP_SUBC)) |-> (ex_o == '0 || ex_o == '1))
    else $error("borrow EX out of range"); // R2
endmodule

// File: tb/alu_ex_core_test.sv
`timescale 1ns/1ps
module alu_ex_core_test;
  localparam int W = 16;
  localparam int DIV_MAX = 2 * W + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [4:0]    op = '0;
  logic [W-1:0]  b = '0, a = '0, ex = '0;
  logic [W-1:0]  result, ex_out;
  logic          ex_we, cond, done;
  logic [1:0]    cycles;
  int            n_chk = 0;
  int            n_fail = 0;

  always #2.5 clk = ~clk;

  alu_ex_core uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .b_i(b), .a_i(a), .ex_i(ex),
    .result_o(result), .ex_o(ex_out), .ex_we_o(ex_we), .cond_o(cond),
    .cycles_o(cycles), .done_o(done)
  );

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference model from the requirements
  task automatic model(input logic [4:0] o, input logic [W-1:0] bb, aa, ee,
                       output logic [W-1:0] r, output logic [W-1:0] x,
                       output logic we, output logic c, output int cy);
    longint ub, ua, ue, sb, sa, t;
    ub = longint'(bb); ua = longint'(aa); ue = longint'(ee);
    sb = longint'($signed(bb)); sa = longint'($signed(aa));
    r = bb; x = '0; we = 1'b0; c = 1'b1; cy = 1;
    case (o)
      5'h01: r = aa;
      5'h09: r = bb & aa;
      5'h0a: r = bb | aa;
      5'h0b: r = bb ^ aa;
      5'h02: begin t = ub + ua; r = W'(t); x = (t > 65535) ? 16'h0001 : 16'h0; we = 1; cy = 2; end
      5'h03: begin t = ub - ua; r = W'(t); x = (t < 0) ? 16'hffff : 16'h0; we = 1; cy = 2; end
      5'h1a: begin t = ub + ua + ue; r = W'(t); x = (t > 65535) ? 16'h0001 : 16'h0; we = 1; cy = 3; end
      5'h1b: begin t = ub - ua + ue; r = W'(t); x = (t < 0) ? 16'hffff : 16'h0; we = 1; cy = 3; end
      5'h04: begin t = ub * ua; r = W'(t); x = W'(t >>> 16); we = 1; cy = 2; end
      5'h05: begin t = sb * sa; r = W'(t); x = W'(t >>> 16); we = 1; cy = 2; end
      5'h06: begin
        we = 1; cy = 3;
        if (ua == 0) begin r = 0; x = 0; end
        else begin r = W'(ub / ua); x = W'((ub * 65536) / ua); end
      end
      5'h07: begin
        we = 1; cy = 3;
        if (sa == 0) begin r = 0; x = 0; end
        else begin r = W'(sb / sa); x = W'((sb * 65536) / sa); end
      end
      5'h08: begin cy = 3; r = (ua == 0) ? 16'h0 : W'(ub % ua); end
      5'h0c: begin t = (ua >= 48) ? 0 : ((ub << 16) >> ua); r = W'(t >>> 16); x = W'(t); we = 1; cy = 2; end
      5'h0d: begin t = (sb * 65536) >>> ((ua > 60) ? 60 : ua); r = W'(t >>> 16); x = W'(t); we = 1; cy = 2; end
      5'h0e: begin t = (ua >= 40) ? 0 : (ub << ua); r = W'(t); x = W'(t >>> 16); we = 1; cy = 2; end
      5'h10: begin c = (bb & aa) != 0; cy = c ? 2 : 3; end
      5'h11: begin c = (bb & aa) == 0; cy = c ? 2 : 3; end
      5'h12: begin c = bb == aa; cy = c ? 2 : 3; end
      5'h13: begin c = bb != aa; cy = c ? 2 : 3; end
      5'h14: begin c = ub > ua; cy = c ? 2 : 3; end
      5'h15: begin c = sb > sa; cy = c ? 2 : 3; end
      5'h16: begin c = ub < ua; cy = c ? 2 : 3; end
      5'h17: begin c = sb < sa; cy = c ? 2 : 3; end
      default: ;
    endcase
  endtask

  // issue one operation, wait for done, compare
  task automatic run(input string tag, input logic [4:0] o, input logic [W-1:0] bb, aa, ee);
    logic [W-1:0] er, ex_e;
    logic ew, ec;
    int ecy, lat;
    model(o, bb, aa, ee, er, ex_e, ew, ec, ecy);
    @(negedge clk);
    op = o; b = bb; a = aa; ex = ee; start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 100);
    if (o == 5'h06 || o == 5'h07 || o == 5'h08)
      chk("R13", "divide latency bound", longint'(lat <= DIV_MAX), 1);
    else
      chk("R1", "latency", lat, 1);
    chk(tag, "result", result, er);
    chk(tag, "ex_we", ex_we, ew);
    if (ew) chk(tag, "ex", ex_out, ex_e);
    chk(tag, "cond", cond, ec);
    chk("R12", "cycles", cycles, ecy);
    @(negedge clk);
    chk("R1", "done single pulse", done, 0);
  endtask

  task automatic t_reset();
    chk("R1", "reset done", done, 0);
    chk("R1", "reset ex_we", ex_we, 0);
    chk("R1", "reset result", result, 0);
  endtask

  task automatic t_add_sub();
    run("R2", 5'h02, 16'hfffe, 16'h0001, 16'h0);
    run("R2", 5'h02, 16'hffff, 16'h0001, 16'h0);
    run("R2", 5'h02, 16'h8000, 16'h8000, 16'h1234);
    run("R2", 5'h03, 16'h0005, 16'h0005, 16'h0);
    run("R2", 5'h03, 16'h0005, 16'h0006, 16'h0);
  endtask

  task automatic t_carry();
    run("R3", 5'h1a, 16'hfffe, 16'h0000, 16'h0001);
    run("R3", 5'h1a, 16'hffff, 16'h0000, 16'h0001);
    run("R3", 5'h1a, 16'hffff, 16'hffff, 16'hffff);
    run("R3", 5'h1b, 16'h0003, 16'h0004, 16'h0001);
    run("R3", 5'h1b, 16'h0003, 16'h0005, 16'h0001);
    run("R3", 5'h1b, 16'h0000, 16'h0001, 16'hffff);
  endtask

  task automatic t_mul();
    run("R4", 5'h04, 16'hffff, 16'hffff, 16'h0);
    run("R4", 5'h04, 16'h1234, 16'h0100, 16'h0);
    run("R4", 5'h05, 16'hffff, 16'hffff, 16'h0);
    run("R4", 5'h05, 16'h8000, 16'h0002, 16'h0);
    run("R4", 5'h05, 16'hfff0, 16'h0010, 16'h0);
  endtask

  task automatic t_div();
    run("R5", 5'h06, 16'd100, 16'd7, 16'h0);
    run("R5", 16'h06, 16'hffff, 16'h0003, 16'h0);
    run("R5", 5'h06, 16'd1, 16'd3, 16'h0);
    run("R6", 5'h07, 16'hfff9, 16'h0002, 16'h0);
    run("R6", 5'h07, 16'h0007, 16'hfffe, 16'h0);
    run("R6", 5'h07, 16'hfff9, 16'hfffe, 16'h0);
    run("R6", 5'h07, 16'h8000, 16'hffff, 16'h0);
    run("R6", 5'h07, 16'h0007, 16'h0003, 16'h0);
  endtask

  task automatic t_div_zero();
    run("R7", 5'h06, 16'h1234, 16'h0000, 16'h0);
    run("R7", 5'h07, 16'h8001, 16'h0000, 16'h0);
    run("R7", 5'h08, 16'h4321, 16'h0000, 16'h0);
  endtask

  task automatic t_rem();
    run("R8", 5'h08, 16'd100, 16'd7, 16'h5555);
    run("R8", 5'h08, 16'hffff, 16'h0010, 16'h0);
    run("R8", 5'h08, 16'd3, 16'd9, 16'h0);
  endtask

  task automatic t_shift();
    run("R9", 5'h0c, 16'h8421, 16'd0, 16'h0);
    run("R9", 5'h0c, 16'h8421, 16'd4, 16'h0);
    run("R9", 5'h0c, 16'h8421, 16'd16, 16'h0);
    run("R9", 5'h0c, 16'h8421, 16'd40, 16'h0);
    run("R9", 5'h0d, 16'h8421, 16'd4, 16'h0);
    run("R9", 5'h0d, 16'h8421, 16'd20, 16'h0);
    run("R9", 5'h0d, 16'h8421, 16'd300, 16'h0);
    run("R9", 5'h0e, 16'h8421, 16'd4, 16'h0);
    run("R9", 5'h0e, 16'h8421, 16'd17, 16'h0);
    run("R9", 5'h0e, 16'h8421, 16'd33, 16'h0);
  endtask

  task automatic t_plain();
    run("R10", 5'h01, 16'h1111, 16'hbeef, 16'h7777);
    run("R10", 5'h09, 16'hf0f0, 16'h3c3c, 16'h7777);
    run("R10", 5'h0a, 16'hf0f0, 16'h3c3c, 16'h7777);
    run("R10", 5'h0b, 16'hf0f0, 16'h3c3c, 16'h7777);
    run("R10", 5'h18, 16'hcafe, 16'h0001, 16'h7777);
    run("R10", 5'h00, 16'h0bad, 16'h0002, 16'h7777);
  endtask

  task automatic t_tests();
    for (int k = 0; k < 8; k++) begin
      run("R11", 5'h10 + 5'(k), 16'h8001, 16'h0001, 16'h0);
      run("R11", 5'h10 + 5'(k), 16'h0001, 16'h8001, 16'h0);
      run("R11", 5'h10 + 5'(k), 16'h00f0, 16'h0f00, 16'h0);
      run("R11", 5'h10 + 5'(k), 16'h1234, 16'h1234, 16'h0);
    end
  endtask

  task automatic t_busy_ignore();
    int lat, extra;
    @(negedge clk);
    op = 5'h06; b = 16'd100; a = 16'd7; ex = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    op = 5'h02; b = 16'h0001; a = 16'h0001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R1", "busy start dropped: result", result, 16'd14);
    chk("R1", "busy start dropped: ex", ex_out, 16'h4924);
    chk("R1", "busy start dropped: cycles", cycles, 3);
    extra = 0;
    repeat (6) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R1", "no completion from dropped start", extra, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add_sub();
    t_carry();
    t_mul();
    t_div();
    t_div_zero();
    t_rem();
    t_shift();
    t_plain();
    t_tests();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule